// File: doc/BRIEF.md
# Source-Gated APB Register Slave

This block is an APB slave for the private peripheral window. It holds a small bank of 32-bit registers on word-aligned offsets. Each transfer carries one sideband bit that tells the slave who started it. A value of 0 means software running on the processor. A value of 1 means debug hardware.

The lower part of the bank is shared, so either source may read and write it. The upper part belongs to the debugger. Software may not change these registers, and a software read of one of them returns zero. Misaligned offsets and offsets past the last register are refused with an error response. The slave completes every transfer with no wait states. Byte strobes select lanes in little-endian order.

The peripheral is placed somewhere in the private window 0xE0042000 to 0xE00FF000. It sees only the low address bits of its own slot.

Top module: `srcgate_apb_slave`

## Requirements
- R1: After reset, every register reads as 0 and `pslverr` is low.
- R2: `pready` is always high, so each transfer ends in its access phase. `pslverr` is high only in an access phase (`psel` and `penable` both high). A write takes effect at the clock edge that ends the access phase. A setup phase that is not followed by an access phase changes no register.
- R3: Word indices 0 to NUM_SHARED-1 are shared (offsets 0x00, 0x04, 0x08, 0x0C by default). Writes and reads of these registers from either source succeed with `pslverr` low.
- R4: Word indices NUM_SHARED to NUM_REGS-1 are debugger-only (offsets 0x10 to 0x1C by default). With `psrc`=1 they can be written and read back with `pslverr` low.
- R5: A write with `psrc`=0 to a debugger-only register leaves every register unchanged and raises `pslverr`.
- R6: A read with `psrc`=0 of a debugger-only register returns 0 with `pslverr` low.
- R7: An access with `paddr[1:0]` not equal to 0 raises `pslverr`, changes no register and returns 0 on a read.
- R8: During a permitted write, `pstrb[k]` enables data bits 8k+7 to 8k. This is little-endian lane order, so bit 0 of `pstrb` selects the byte at the lowest address. Lanes that are not enabled keep their old value.
- R9: An aligned access whose word index (`paddr[ADDR_W-1:2]`) is NUM_REGS or above raises `pslverr`, writes nothing and returns 0 on a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock |
| presetn | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase marker |
| pwrite | input | 1 | 1 = write, 0 = read |
| psrc | input | 1 | Transfer source: 0 = software, 1 = debugger |
| paddr | input | ADDR_W (12) | Byte offset within the slave's slot |
| pwdata | input | DATA_W (32) | Write data |
| pstrb | input | DATA_W/8 (4) | Write byte-lane enables, bit 0 = lowest byte |
| prdata | output | DATA_W (32) | Read data, valid in the access phase |
| pready | output | 1 | Transfer complete (always high) |
| pslverr | output | 1 | Error response, valid in the access phase |

## Verification
`prdata` and `pslverr` are combinational in the access phase. The bench samples them one nanosecond after it raises `penable`, before the clock edge that closes the transfer. A write becomes visible from that closing edge onward. The reference model therefore updates only after that edge, and a later read in the next transfer observes the new contents. `pready` and the rule that `pslverr` is low outside an access phase are compared one nanosecond after every rising edge, including the reset cycles.

// File: rtl/srcgate_pkg.sv
package srcgate_pkg;

  localparam int BYTE_W = 8;

  // Classification of the transfer currently on the bus
  typedef struct packed {
    logic err;      // transfer is refused with an error response
    logic hide_rd;  // read data must be masked to zero
  } access_cls_t;

endpackage

// File: rtl/srcgate_rst_sync.sv
module srcgate_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n = sync_q[1];

endmodule

// File: rtl/srcgate_decode.sv
module srcgate_decode
  import srcgate_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int NUM_REGS   = 8,
  parameter int NUM_SHARED = 4,
  localparam int IDX_W     = $clog2(NUM_REGS),
  localparam int WORD_W    = ADDR_W - 2
) (
  input  logic [ADDR_W-1:0] paddr,
  input  logic              pwrite,
  input  logic              psrc,
  output logic [IDX_W-1:0]  idx,
  output access_cls_t       cls
);

  logic [WORD_W-1:0] word;
  logic              aligned;
  logic              in_range;
  logic              dbg_only;

  always_comb begin
    word     = paddr[ADDR_W-1:2];
    idx      = word[IDX_W-1:0];
    aligned  = (paddr[1:0] == 2'b00);
    in_range = (word < WORD_W'(NUM_REGS));
    dbg_only = ({1'b0, idx} >= (IDX_W+1)'(NUM_SHARED));
    cls.err     = !aligned || !in_range || (pwrite && !psrc && dbg_only);
    cls.hide_rd = !psrc && dbg_only;
  end

endmodule

// File: rtl/srcgate_regbank.sv
module srcgate_regbank
  import srcgate_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 32,
  localparam int IDX_W   = $clog2(NUM_REGS),
  localparam int STRB_W  = DATA_W / BYTE_W
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [IDX_W-1:0]                 wr_idx,
  input  logic [DATA_W-1:0]                wr_data,
  input  logic [STRB_W-1:0]                wr_strb,
  output logic [NUM_REGS-1:0][DATA_W-1:0]  regs_q
);

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    logic              sel;
    logic [DATA_W-1:0] d_next;

    assign sel = wr_en && (wr_idx == IDX_W'(r));

    for (genvar b = 0; b < STRB_W; b++) begin : g_lane
      always_comb begin
        if (sel && wr_strb[b]) d_next[b*BYTE_W +: BYTE_W] = wr_data[b*BYTE_W +: BYTE_W];
        else                   d_next[b*BYTE_W +: BYTE_W] = regs_q[r][b*BYTE_W +: BYTE_W];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   regs_q[r] <= '0;
      else if (sel) regs_q[r] <= d_next;
    end
  end

  AST_NO_WRITE_WITHOUT_EN: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(regs_q)); // R2

endmodule

// File: rtl/srcgate_apb_slave.sv
module srcgate_apb_slave
  import srcgate_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 32,
  parameter int NUM_REGS   = 8,
  parameter int NUM_SHARED = 4,
  localparam int IDX_W     = $clog2(NUM_REGS),
  localparam int STRB_W    = DATA_W / BYTE_W,
  localparam int WORD_W    = ADDR_W - 2
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic              psrc,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  input  logic [STRB_W-1:0] pstrb,
  output logic [DATA_W-1:0] prdata,
  output logic              pready,
  output logic              pslverr
);

  logic                            rst_n;
  logic [IDX_W-1:0]                idx;
  access_cls_t                     cls;
  logic                            acc;
  logic                            wr_en;
  logic [NUM_REGS-1:0][DATA_W-1:0] regs_q;

  srcgate_rst_sync u_rst (
    .clk    (pclk),
    .arst_n (presetn),
    .rst_n  (rst_n)
  );

  srcgate_decode #(
    .ADDR_W     (ADDR_W),
    .NUM_REGS   (NUM_REGS),
    .NUM_SHARED (NUM_SHARED)
  ) u_dec (
    .paddr  (paddr),
    .pwrite (pwrite),
    .psrc   (psrc),
    .idx    (idx),
    .cls    (cls)
  );

  srcgate_regbank #(
    .NUM_REGS (NUM_REGS),
    .DATA_W   (DATA_W)
  ) u_bank (
    .clk     (pclk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_idx  (idx),
    .wr_data (pwdata),
    .wr_strb (pstrb),
    .regs_q  (regs_q)
  );

  always_comb begin
    acc     = psel && penable;
    wr_en   = acc && pwrite && !cls.err;
    pslverr = acc && cls.err;
    pready  = 1'b1;
    if (acc && !pwrite && !cls.err && !cls.hide_rd) prdata = regs_q[idx];
    else                                            prdata = '0;
  end

  // Independent view of the address used only by the checks below
  logic [WORD_W-1:0] chk_word;
  logic              chk_dbg_region;
  assign chk_word       = paddr[ADDR_W-1:2];
  assign chk_dbg_region = (paddr[1:0] == 2'b00) &&
                          (chk_word >= WORD_W'(NUM_SHARED)) &&
                          (chk_word <  WORD_W'(NUM_REGS));

  AST_SW_DBG_WR_IGNORED: assert property (@(posedge pclk) disable iff (!rst_n)
    (psel && penable && pwrite && !psrc && chk_dbg_region) |=> $stable(regs_q)); // R5
  AST_SW_DBG_WR_ERR: assert property (@(posedge pclk) disable iff (!rst_n)
    (psel && penable && pwrite && !psrc && chk_dbg_region) |-> pslverr); // R5
  AST_SW_DBG_RD_ZERO: assert property (@(posedge pclk) disable iff (!rst_n)
    (psel && penable && !pwrite && !psrc && chk_dbg_region) |-> (prdata == '0 && !pslverr)); // R6
  AST_MISALIGN_NO_WRITE: assert property (@(posedge pclk) disable iff (!rst_n)
    (psel && penable && paddr[1:0] != 2'b00) |=> $stable(regs_q)); // R7
  AST_MISALIGN_ERR: assert property (@(posedge pclk) disable iff (!rst_n)
    (psel && penable && paddr[1:0] != 2'b00) |-> pslverr); // R7
  AST_ERR_ONLY_IN_ACCESS: assert property (@(posedge pclk) disable iff (!rst_n)
    !(psel && penable) |-> !pslverr); // R2

endmodule

// File: tb/srcgate_apb_slave_tb.sv
`timescale 1ns/1ps
module srcgate_apb_slave_tb;

  logic        pclk;
  logic        presetn;
  logic        psel, penable, pwrite, psrc;
  logic [11:0] paddr;
  logic [31:0] pwdata;
  logic [3:0]  pstrb;
  logic [31:0] prdata;
  logic        pready, pslverr;

  int compares   = 0;
  int mismatches = 0;
  logic [31:0] model [8];
  logic [31:0] lfsr = 32'h1ACE_B00C;

  srcgate_apb_slave u_dut (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .psrc(psrc), .paddr(paddr), .pwdata(pwdata),
    .pstrb(pstrb), .prdata(prdata), .pready(pready), .pslverr(pslverr)
  );

  initial pclk = 1'b0;
  always #2.5 pclk = ~pclk;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    compares++;
    if (!ok) begin
      mismatches++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compares, mismatches);
    $finish;
  endtask

  // Every cycle: handshake rules (R2)
  always @(posedge pclk) begin
    #1;
    check(pready === 1'b1, "R2", "pready", {31'd0, pready}, 32'd1);
    if (!(psel && penable))
      check(pslverr === 1'b0, "R2", "pslverr idle", {31'd0, pslverr}, 32'd0);
  end

  // One APB transfer against the reference model
  task automatic xfer(input bit wr, input bit src, input logic [11:0] addr,
                      input logic [31:0] data, input logic [3:0] strb, input string tag_in);
    int idx;
    bit aligned, inr, dbg, err;
    logic [31:0] exp_rd;
    string tag;
    idx     = int'(addr >> 2);
    aligned = (addr[1:0] == 2'b00);
    inr     = idx < 8;
    dbg     = inr && idx >= 4;
    err     = !aligned || !inr || (wr && !src && dbg);
    exp_rd  = (!err && !(!src && dbg)) ? model[idx] : 32'd0;
    if (tag_in != "")          tag = tag_in;
    else if (!aligned)         tag = "R7";
    else if (!inr)             tag = "R9";
    else if (!src && dbg)      tag = wr ? "R5" : "R6";
    else if (wr && strb != 4'hF) tag = "R8";
    else if (dbg)              tag = "R4";
    else                       tag = "R3";
    @(negedge pclk);
    psel = 1'b1; penable = 1'b0; pwrite = wr; psrc = src;
    paddr = addr; pwdata = data; pstrb = strb;
    @(negedge pclk);
    penable = 1'b1;
    #1;
    check(pslverr === err, tag, "pslverr", {31'd0, pslverr}, {31'd0, err});
    if (!wr) check(prdata === exp_rd, tag, "prdata", prdata, exp_rd);
    @(posedge pclk);
    if (wr && !err)
      for (int b = 0; b < 4; b++)
        if (strb[b]) model[idx][b*8 +: 8] = data[b*8 +: 8];
    @(negedge pclk);
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic read_all(input bit src, input string tag);
    for (int i = 0; i < 8; i++) xfer(1'b0, src, 12'(i*4), 32'd0, 4'h0, tag);
  endtask

  initial begin
    repeat (100000) @(posedge pclk);
    check(1'b0, "WDOG", "watchdog expired", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    for (int i = 0; i < 8; i++) model[i] = 32'd0;
    psel = 0; penable = 0; pwrite = 0; psrc = 0;
    paddr = '0; pwdata = '0; pstrb = '0;
    presetn = 1'b0;
    repeat (4) @(posedge pclk);
    @(negedge pclk) presetn = 1'b1;
    repeat (3) @(posedge pclk);

    // R1: reset contents
    read_all(1'b1, "R1");
    xfer(0, 0, 12'h000, 0, 4'h0, "R1");

    // R3: shared registers from both sources
    xfer(1, 0, 12'h000, 32'h1122_3344, 4'hF, "R3");
    xfer(0, 0, 12'h000, 0, 4'h0, "R3");
    xfer(0, 1, 12'h000, 0, 4'h0, "R3");
    xfer(1, 1, 12'h004, 32'hCAFE_F00D, 4'hF, "R3");
    xfer(0, 0, 12'h004, 0, 4'h0, "R3");
    xfer(1, 0, 12'h00C, 32'h0BAD_BEEF, 4'hF, "R3");

    // R4: debugger-only registers from the debugger
    xfer(1, 1, 12'h014, 32'hDEAD_0005, 4'hF, "R4");
    xfer(1, 1, 12'h01C, 32'h7777_0007, 4'hF, "R4");
    xfer(0, 1, 12'h014, 0, 4'h0, "R4");
    xfer(0, 1, 12'h01C, 0, 4'h0, "R4");

    // R5: software write to debugger-only is refused
    xfer(1, 0, 12'h014, 32'hFFFF_FFFF, 4'hF, "R5");
    xfer(1, 0, 12'h010, 32'h1234_5678, 4'hF, "R5");
    read_all(1'b1, "R5");

    // R6: software read of debugger-only returns zero
    xfer(0, 0, 12'h014, 0, 4'h0, "R6");
    xfer(0, 0, 12'h01C, 0, 4'h0, "R6");

    // R7: misaligned accesses
    xfer(1, 1, 12'h005, 32'hAAAA_AAAA, 4'hF, "R7");
    xfer(1, 0, 12'h002, 32'h5555_5555, 4'hF, "R7");
    xfer(1, 1, 12'h017, 32'h5555_5555, 4'hF, "R7");
    xfer(0, 1, 12'h001, 0, 4'h0, "R7");
    read_all(1'b1, "R7");

    // R8: byte strobes in little-endian lane order
    xfer(1, 0, 12'h008, 32'hAABB_CCDD, 4'b0001, "R8");
    xfer(0, 0, 12'h008, 0, 4'h0, "R8");
    xfer(1, 1, 12'h008, 32'h1100_0000, 4'b1000, "R8");
    xfer(0, 0, 12'h008, 0, 4'h0, "R8");
    xfer(1, 1, 12'h018, 32'h0000_9900, 4'b0110, "R8");
    xfer(0, 1, 12'h018, 0, 4'h0, "R8");

    // R9: beyond the last register
    xfer(1, 1, 12'h020, 32'h0F0F_0F0F, 4'hF, "R9");
    xfer(1, 0, 12'hFFC, 32'h0F0F_0F0F, 4'hF, "R9");
    xfer(0, 1, 12'h020, 0, 4'h0, "R9");
    read_all(1'b1, "R9");

    // R2: setup phase with no access phase changes nothing
    @(negedge pclk);
    psel = 1; penable = 0; pwrite = 1; psrc = 1;
    paddr = 12'h000; pwdata = 32'hFEED_FACE; pstrb = 4'hF;
    repeat (2) @(negedge pclk);
    psel = 0;
    xfer(0, 1, 12'h000, 0, 4'h0, "R2");

    // Mixed traffic
    for (int n = 0; n < 400; n++) begin
      logic [11:0] a;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      a = (lfsr[7:4] < 4'd12) ? {6'd0, lfsr[7:4], (lfsr[8] & lfsr[9]) ? lfsr[11:10] : 2'b00}
                              : {lfsr[7:0], 4'd0};
      xfer(lfsr[12], lfsr[13], a, {lfsr[15:0], lfsr[31:16]}, lfsr[19:16], "");
    end
    read_all(1'b1, "");

    finish_run();
  end

endmodule